// File: doc/BRIEF.md
# Two-byte result readout sequencer

This block hands a 10-bit conversion result to an 8-bit processor data bus as two successive byte reads. The result comes in already latched from the conversion controller. The bus side uses an active-low chip select and an active-low read strobe. The block keeps a one-bit byte pointer that says which half of the result the next read returns. A data-enable output takes the place of a tri-state control.

The result is left-justified over the two reads. The first read returns the eight most significant bits. The second read returns the two least significant bits in the top two lanes of the byte, and the rest of that byte is zero.

The pointer goes back to the first byte whenever the conversion controller reports a new latched result or the start of a new conversion. Every read access also gives a one-cycle pulse that the interrupt logic uses to clear its end-of-conversion flag. All inputs are taken to be synchronous to the block clock.

Top module: `byteReadout`

## Requirements
- R1: `dataOe` is high in exactly those cycles where `csN` and `rdN` are both low. It follows them combinationally.
- R2: While `dataOe` is low, `dataOut` is all zero.
- R3: With the pointer on the first byte, a read returns result bits 9..2 on `dataOut[7:0]`. Bit 9 is on lane 7.
- R4: With the pointer on the second byte, a read returns result bit 1 on lane 7 and bit 0 on lane 6. Lanes 5..0 are zero.
- R5: `readPulse` is high for exactly one cycle. That cycle follows the first clock edge that samples `csN` and `rdN` both low after an edge that did not. Holding the access for longer gives no further pulse.
- R6: The pointer toggles at a clock edge that samples `rdN` high, `rdN` low at the edge before, and `csN` low. A rising read strobe while `csN` is high leaves the pointer unchanged. A held access leaves the pointer unchanged.
- R7: After the second byte has been read, the next read returns the first byte again.
- R8: At a clock edge that samples `newResult` or `startConv` high, the pointer returns to the first byte. This takes priority over a toggle at the same edge.
- R9: After reset the pointer is on the first byte and `readPulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| result | input | RES_W (10) | Latched conversion result |
| newResult | input | 1 | One-cycle pulse: a new result has been latched |
| startConv | input | 1 | One-cycle pulse: a new conversion has started |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| dataOut | output | BUS_W (8) | Byte presented to the bus; zero when not enabled |
| dataOe | output | 1 | Bus drive enable (stands in for tri-state) |
| readPulse | output | 1 | One-cycle pulse per read access, for the interrupt logic |

## Verification
The bench sweeps all 1024 result values. For each value it rebuilds the number as `{first, second[7:6]}` and compares it with the input. A swapped lane or a shifted field would break the rebuilt value at once. A wrong padding mask would leave garbage in lanes 5..0.

Several cases target the pointer:
- A third read must wrap back to the first byte. A design that sticks on the low byte fails here.
- A rewind pulse that lands on the same edge as a rising read strobe must win. A design with the wrong priority would return the low byte.
- A read strobe toggled with chip select high must not advance the pointer.
- A long held access must give one pulse and no advance. A level-sensitive design would pulse every cycle.

// File: rtl/byteReadout_pkg.sv
package byteReadout_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic drive;   // bus access active this cycle
    logic selLow;  // pointer: 0 = high byte, 1 = low byte
  } pathStrobes_t;

endpackage

// File: rtl/byteReadoutCtl.sv
module byteReadoutCtl
  import byteReadout_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         rdN,
  input  logic         newResult,
  input  logic         startConv,
  output pathStrobes_t strobes,
  output logic         readPulse
);

  logic rdNq;      // read strobe seen at the previous edge
  logic accessQ;   // access seen at the previous edge
  logic ptrLow;    // byte pointer
  logic access;
  logic rdRise;
  logic rewind;

  assign access = !csN && !rdN;
  assign rdRise = rdN && !rdNq && !csN;
  assign rewind = newResult || startConv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdNq      <= 1'b1;
      accessQ   <= 1'b0;
      ptrLow    <= 1'b0;
      readPulse <= 1'b0;
    end else begin
      rdNq      <= rdN;
      accessQ   <= access;
      readPulse <= access && !accessQ;
      if (rewind) begin
        ptrLow <= 1'b0;
      end else if (rdRise) begin
        ptrLow <= !ptrLow;
      end
    end
  end

  always_comb begin
    strobes.drive  = access;
    strobes.selLow = ptrLow;
  end

endmodule

// File: rtl/byteReadoutPath.sv
module byteReadoutPath
  import byteReadout_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic [RES_W-1:0] result,
  input  pathStrobes_t     strobes,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOe
);

  localparam int LO_W  = RES_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  logic [BUS_W-1:0] highByte;
  logic [BUS_W-1:0] lowByte;
  logic [BUS_W-1:0] byteMux;

  assign highByte = result[RES_W-1 -: BUS_W];
  assign lowByte  = BUS_W'(result[LO_W-1:0]) << PAD_W;
  assign byteMux  = strobes.selLow ? lowByte : highByte;
  assign dataOe   = strobes.drive;

  // Per-lane gating: a lane carries data only while the bus is driven.
  for (genvar lane = 0; lane < BUS_W; lane++) begin : g_lane
    assign dataOut[lane] = strobes.drive & byteMux[lane];
  end

endmodule

// File: rtl/byteReadout.sv
module byteReadout
  import byteReadout_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] result,
  input  logic             newResult,
  input  logic             startConv,
  input  logic             csN,
  input  logic             rdN,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOe,
  output logic             readPulse
);

  pathStrobes_t strobes;

  byteReadoutCtl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .rdN       (rdN),
    .newResult (newResult),
    .startConv (startConv),
    .strobes   (strobes),
    .readPulse (readPulse)
  );

  byteReadoutPath #(
    .RES_W (RES_W),
    .BUS_W (BUS_W)
  ) u_path (
    .result  (result),
    .strobes (strobes),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

endmodule

// File: rtl/byteReadoutChk.sv
module byteReadoutChk #(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             newResult,
  input logic             startConv,
  input logic             csN,
  input logic             rdN,
  input logic [BUS_W-1:0] dataOut,
  input logic             dataOe,
  input logic             readPulse,
  input logic             selLow
);

  localparam int LO_W = RES_W - BUS_W;
  localparam logic [BUS_W-1:0] PAD_MASK = {BUS_W{1'b1}} >> LO_W;

  logic rdNSeen;
  logic riseSeen;
  logic rewindSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdNSeen <= 1'b1;
    else       rdNSeen <= rdN;
  end

  assign riseSeen   = rdN && !rdNSeen && !csN;
  assign rewindSeen = newResult || startConv;

  a_r1_oe_on_access: assert property (@(posedge clk) disable iff (!rstN)
    dataOe == (!csN && !rdN));

  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));

  a_r4_low_pad: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && selLow) |-> ((dataOut & PAD_MASK) == '0));

  a_r5_pulse_after_access: assert property (@(posedge clk) disable iff (!rstN)
    readPulse |-> $past(!csN && !rdN));

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    readPulse |=> !readPulse);

  a_r6_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (riseSeen && !rewindSeen) |=> (selLow != $past(selLow)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!riseSeen && !rewindSeen) |=> $stable(selLow));

  a_r8_rewind: assert property (@(posedge clk) disable iff (!rstN)
    rewindSeen |=> !selLow);

endmodule

bind byteReadout byteReadoutChk #(
  .RES_W (RES_W),
  .BUS_W (BUS_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .newResult (newResult),
  .startConv (startConv),
  .csN       (csN),
  .rdN       (rdN),
  .dataOut   (dataOut),
  .dataOe    (dataOe),
  .readPulse (readPulse),
  .selLow    (strobes.selLow)
);

// File: tb/sim_byteReadout.sv
module sim_byteReadout;

  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 10;
  localparam int BUS_W = 8;
  localparam int WATCHDOG = 50000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [RES_W-1:0] result = '0;
  logic             newResult = 1'b0;
  logic             startConv = 1'b0;
  logic             csN = 1'b1;
  logic             rdN = 1'b1;
  logic [BUS_W-1:0] dataOut;
  logic             dataOe;
  logic             readPulse;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byteReadout #(.RES_W(RES_W), .BUS_W(BUS_W)) u0 (
    .clk(clk), .rstN(rstN), .result(result), .newResult(newResult),
    .startConv(startConv), .csN(csN), .rdN(rdN),
    .dataOut(dataOut), .dataOe(dataOe), .readPulse(readPulse)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] expHigh(input int v);
    return 8'((v >> 2) & 8'hFF);
  endfunction

  function automatic logic [7:0] expLow(input int v);
    return 8'((v & 3) << 6);
  endfunction

  // One complete read: strobe low for one edge, then a rising strobe with
  // chip select still low, then release.
  task automatic readByte(output logic [7:0] b, output logic p);
    @(negedge clk); csN = 1'b0; rdN = 1'b0;
    @(negedge clk); b = dataOut; p = readPulse;
    rdN = 1'b1;
    @(negedge clk); csN = 1'b1;
  endtask

  task automatic pulseNew();
    @(negedge clk); newResult = 1'b1;
    @(negedge clk); newResult = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] b1, b2, b3;
    logic p1, p2, p3;

    result = 10'h2B5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 readPulse after reset", readPulse, 0);
    chk("R1 oe idle", dataOe, 0);
    chk("R2 bus zero idle", dataOut, 0);
    readByte(b1, p1);
    chk("R9 first read after reset is high byte", b1, expHigh(10'h2B5));

    // R3 R4 R5 exhaustive sweep
    for (int v = 0; v < (1 << RES_W); v++) begin
      @(negedge clk); result = RES_W'(v);
      pulseNew();
      readByte(b1, p1);
      readByte(b2, p2);
      chk("R3 high byte", b1, expHigh(v));
      chk("R4 low byte", b2, expLow(v));
      chk("R3 R4 rebuilt value", {b1, b2[7:6]}, v);
      chk("R5 pulse on read", {p1, p2}, 2'b11);
    end

    result = 10'h2B5;
    // R7 wrap to first byte
    pulseNew();
    readByte(b1, p1); readByte(b2, p2); readByte(b3, p3);
    chk("R7 third read wraps", b3, expHigh(10'h2B5));

    // R8 startConv rewinds
    pulseNew();
    readByte(b1, p1);
    @(negedge clk); startConv = 1'b1;
    @(negedge clk); startConv = 1'b0;
    readByte(b2, p2);
    chk("R8 startConv rewind", b2, expHigh(10'h2B5));

    // R8 rewind beats a rising strobe at the same edge
    pulseNew();
    @(negedge clk); csN = 1'b0; rdN = 1'b0;
    @(negedge clk); rdN = 1'b1; newResult = 1'b1;
    @(negedge clk); newResult = 1'b0; csN = 1'b1;
    readByte(b1, p1);
    chk("R8 rewind priority", b1, expHigh(10'h2B5));

    // R6 rising strobe with chip select high has no effect
    pulseNew();
    @(negedge clk); csN = 1'b1; rdN = 1'b0;
    chk("R1 oe low with cs high", dataOe, 0);
    @(negedge clk); rdN = 1'b1;
    @(negedge clk);
    readByte(b1, p1);
    chk("R6 no advance without cs", b1, expHigh(10'h2B5));

    // R5 R6 held access: single pulse, no advance
    @(negedge clk); csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    chk("R5 held pulse cycle1", readPulse, 1);
    chk("R1 oe during access", dataOe, 1);
    @(negedge clk);
    chk("R5 held pulse cycle2", readPulse, 0);
    chk("R6 held no advance", dataOut, expLow(10'h2B5));
    @(negedge clk);
    chk("R5 held pulse cycle3", readPulse, 0);
    rdN = 1'b1;
    @(negedge clk);
    chk("R1 oe low rd high", dataOe, 0);
    chk("R2 bus zero rd high", dataOut, 0);
    csN = 1'b1;
    readByte(b1, p1);
    chk("R7 wrap after held low read", b1, expHigh(10'h2B5));

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule